// File: doc/BRIEF.md
# Fetch Command Manager

This block sits in each lane of a vector-thread engine and decides which instruction block the lane runs next. Work reaches it in three ways. The control processor sends broadcast fetches, which cover every configured virtual processor in the lane, and single fetches, which name one processor. A running processor can also ask for its own next block with a thread fetch. Control-processor commands wait in a small in-order queue. Each virtual processor has one pending thread-fetch register. No block is ever fetched implicitly.

For the chosen fetch, the block address is compared against every tag of the lane's block cache at once. On a hit, an execute directive carrying the cache entry number and the target processor goes out on a valid/ready port. On a miss, a one-cycle fill request is raised and the block waits for the fill to finish. The tag is then installed in the entry picked by a round-robin pointer and the directive follows. A processor's thread counts as alive from its first thread fetch until one of its thread blocks completes with no further thread fetch pending. While any thread is alive, no new control-processor command is started.

Top module: `fetch_cmd_mgr`

## Requirements
- R1: After reset no directive and no fill request is presented, and the command queue is ready to accept.
- R2: The command queue accepts exactly CMDQ_DEPTH commands while the directive port is stalled, then drops cmdReady. A command stays in the queue until all of its directives have been taken.
- R3: A broadcast command (cmdKind = 1) produces one directive for each virtual processor 0 to cfgVpCount-1, in ascending order, all with the same entry number and dirThread = 0.
- R4: A single command (cmdKind = 0) produces exactly one directive, for the processor given in cmdVp, with dirThread = 0.
- R5: A directive's dirIdx is the cache entry holding the fetched address. A fetch whose address is resident raises no fill request.
- R6: A fetch whose address is not resident raises fillReqValid for exactly one cycle with the address on fillReqAddr. No directive appears before fillDone. The n-th fill since reset (n counted from 0) installs into entry n mod CACHE_ENTRIES.
- R7: Pending thread fetches are served before queued commands, and the lowest-numbered pending processor goes first. Thread directives carry dirThread = 1.
- R8: While any processor's thread is alive, no new command from the queue is started.
- R9: A thread ends when a completion with doneThread = 1 arrives for its processor, no other thread block of that processor is outstanding and no thread fetch is pending. A thread fetch for the same processor in the same cycle as the completion keeps the thread alive.
- R10: While dirValid is high and dirReady is low, dirValid, dirIdx, dirVp and dirThread hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Control-processor command offered |
| cmdReady | output | 1 | Command queue has room |
| cmdKind | input | 1 | 1 = broadcast fetch, 0 = single fetch |
| cmdVp | input | VPW | Target processor of a single fetch |
| cmdAddr | input | ADDR_W | Block address of the command |
| cfgVpCount | input | CNTW | Number of configured processors in the lane (1 to NUM_VP) |
| tfValid | input | 1 | A processor raises a thread fetch |
| tfVp | input | VPW | Processor raising the thread fetch |
| tfAddr | input | ADDR_W | Block address of the thread fetch |
| doneValid | input | 1 | A block finished executing |
| doneVp | input | VPW | Processor whose block finished |
| doneThread | input | 1 | The finished block came from a thread directive |
| fillReqValid | output | 1 | One-cycle request to load a block |
| fillReqAddr | output | ADDR_W | Address of the block to load |
| fillDone | input | 1 | The requested block is now in the cache |
| dirValid | output | 1 | Execute directive offered |
| dirReady | input | 1 | Execution side takes the directive |
| dirIdx | output | IDXW | Cache entry holding the block |
| dirVp | output | VPW | Processor that runs the block |
| dirThread | output | 1 | Directive comes from a thread fetch |

## Verification
The hardest situation to reach is the overlap of priority, blocking and thread lifetime. A command must sit waiting while two thread fetches are pending out of index order, and a thread block must complete in the same cycle as its processor's next thread fetch. The stimulus holds dirReady low so that one command stalls in the output stage. It then raises thread fetches for processors 2 and 1 and queues a second command behind them. After the port is released, the order of the directives shows the priority. The bench then feeds completions one at a time, with the output watched for any directive that starts early, until only the last completion lets the queued command through.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FREQ,
    ST_FWAIT,
    ST_ISSUE
  } fcmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeThread;  // load current fetch from lowest pending thread register
    logic takeCmd;     // load current fetch from command queue head
    logic latchHit;    // capture hit entry number
    logic install;     // write tag into round-robin victim, capture its number
    logic stepVp;      // broadcast: directive taken, move to next processor
    logic finish;      // last directive of this fetch taken
  } fcmCtl_t;

  localparam logic KIND_SINGLE = 1'b0;
  localparam logic KIND_BCAST  = 1'b1;

endpackage

// File: rtl/fcm_cmd_fifo.sv
module fcm_cmd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  output logic             pushReady,
  input  logic [WIDTH-1:0] pushData,
  output logic             headValid,
  output logic [WIDTH-1:0] headData,
  input  logic             pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pushReady = (count != CW'(DEPTH));
  assign headValid = (count != '0);
  assign headData  = mem[rdPtr];
  assign doPush    = pushValid && pushReady;
  assign doPop     = pop && headValid;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R2
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady && !pop) |=> $stable(wrPtr)); // R2

endmodule

// File: rtl/fcm_tag_store.sv
module fcm_tag_store #(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   lookAddr,
  output logic            hit,
  output logic [IDXW-1:0] hitIdx,
  input  logic            install,
  output logic [IDXW-1:0] victim
);
  logic [AW-1:0]      tagMem [ENTRIES];
  logic [ENTRIES-1:0] tagValid;
  logic [ENTRIES-1:0] hitVec;
  logic [IDXW-1:0]    rrPtr;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hitVec[e] = tagValid[e] && (tagMem[e] == lookAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hitVec[e]) hitIdx = IDXW'(e);
    end
  end

  assign hit    = |hitVec;
  assign victim = rrPtr;

  always_ff @(posedge clk) begin
    if (install) tagMem[rrPtr] <= lookAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagValid <= '0;
      rrPtr    <= '0;
    end else if (install) begin
      tagValid[rrPtr] <= 1'b1;
      rrPtr <= (rrPtr == IDXW'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R5
  AST_INSTALL_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    install |-> !hit); // R6

endmodule

// File: rtl/fcm_datapath.sv
module fcm_datapath
  import fcm_pkg::*;
#(
  parameter int NUM_VP        = 4,
  parameter int CACHE_ENTRIES = 8,
  parameter int ADDR_W        = 16,
  parameter int CMDQ_DEPTH    = 4,
  parameter int THR_OUTST     = 3,
  localparam int VPW  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int CNTW = $clog2(NUM_VP + 1),
  localparam int IDXW = (CACHE_ENTRIES > 1) ? $clog2(CACHE_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcmCtl_t           ctl,
  input  logic              dirValidIn,
  input  logic              dirReady,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdKind,
  input  logic [VPW-1:0]    cmdVp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNTW-1:0]   cfgVpCount,
  input  logic              tfValid,
  input  logic [VPW-1:0]    tfVp,
  input  logic [ADDR_W-1:0] tfAddr,
  input  logic              doneValid,
  input  logic [VPW-1:0]    doneVp,
  input  logic              doneThread,
  output logic              pendAny,
  output logic              thrAny,
  output logic              cmdAvail,
  output logic              hit,
  output logic              lastVp,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [IDXW-1:0]   dirIdx,
  output logic [VPW-1:0]    dirVp,
  output logic              dirThread
);
  localparam int QW = 1 + VPW + ADDR_W;
  localparam int TW = $clog2(THR_OUTST + 1);

  // command queue
  logic [QW-1:0]     headData;
  logic              headKind;
  logic [VPW-1:0]    headVp;
  logic [ADDR_W-1:0] headAddr;
  logic              popCmd;

  // current fetch
  logic [ADDR_W-1:0] curAddr;
  logic [VPW-1:0]    curVp;
  logic              curVec;
  logic              curFromCmd;
  logic [IDXW-1:0]   curIdx;

  // thread state
  logic [NUM_VP-1:0] pendValid;
  logic [ADDR_W-1:0] pendAddr [NUM_VP];
  logic [TW-1:0]     thrCnt [NUM_VP];
  logic [VPW-1:0]    selVp;
  logic              thrBusy;
  logic              fire;

  logic [IDXW-1:0]   hitIdx;
  logic [IDXW-1:0]   victim;

  fcm_cmd_fifo #(.WIDTH(QW), .DEPTH(CMDQ_DEPTH)) u_cmdq (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(cmdValid),
    .pushReady(cmdReady),
    .pushData ({cmdKind, cmdVp, cmdAddr}),
    .headValid(cmdAvail),
    .headData (headData),
    .pop      (popCmd)
  );

  assign headKind = headData[QW-1];
  assign headVp   = headData[ADDR_W +: VPW];
  assign headAddr = headData[ADDR_W-1:0];

  fcm_tag_store #(.ENTRIES(CACHE_ENTRIES), .AW(ADDR_W)) u_tags (
    .clk     (clk),
    .rstN    (rstN),
    .lookAddr(curAddr),
    .hit     (hit),
    .hitIdx  (hitIdx),
    .install (ctl.install),
    .victim  (victim)
  );

  assign fire   = ctl.stepVp || ctl.finish;
  assign popCmd = ctl.finish && curFromCmd;

  // lowest-numbered pending processor
  always_comb begin
    selVp = '0;
    for (int v = NUM_VP - 1; v >= 0; v--) begin
      if (pendValid[v]) selVp = VPW'(v);
    end
  end

  always_comb begin
    thrBusy = 1'b0;
    for (int v = 0; v < NUM_VP; v++) begin
      if (thrCnt[v] != '0) thrBusy = 1'b1;
    end
  end

  assign pendAny = |pendValid;
  assign thrAny  = pendAny || thrBusy;
  assign lastVp  = !curVec || ((CNTW'(curVp) + CNTW'(1)) >= cfgVpCount);

  // pending thread-fetch registers and outstanding thread-block counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= '0;
      for (int v = 0; v < NUM_VP; v++) begin
        pendAddr[v] <= '0;
        thrCnt[v]   <= '0;
      end
    end else begin
      for (int v = 0; v < NUM_VP; v++) begin
        if (tfValid && tfVp == VPW'(v)) begin
          pendValid[v] <= 1'b1;
          pendAddr[v]  <= tfAddr;
        end else if (ctl.takeThread && selVp == VPW'(v)) begin
          pendValid[v] <= 1'b0;
        end
        thrCnt[v] <= thrCnt[v]
                   + TW'(fire && !curFromCmd && curVp == VPW'(v))
                   - TW'(doneValid && doneThread && doneVp == VPW'(v) && thrCnt[v] != '0);
      end
    end
  end

  // current fetch registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr    <= '0;
      curVp      <= '0;
      curVec     <= 1'b0;
      curFromCmd <= 1'b0;
      curIdx     <= '0;
    end else begin
      if (ctl.takeThread) begin
        curAddr    <= pendAddr[selVp];
        curVp      <= selVp;
        curVec     <= 1'b0;
        curFromCmd <= 1'b0;
      end else if (ctl.takeCmd) begin
        curAddr    <= headAddr;
        curVp      <= (headKind == KIND_BCAST) ? '0 : headVp;
        curVec     <= (headKind == KIND_BCAST);
        curFromCmd <= 1'b1;
      end
      if (ctl.latchHit) curIdx <= hitIdx;
      if (ctl.install)  curIdx <= victim;
      if (ctl.stepVp)   curVp  <= curVp + 1'b1;
    end
  end

  assign fillAddr  = curAddr;
  assign dirIdx    = curIdx;
  assign dirVp     = curVp;
  assign dirThread = !curFromCmd;

  AST_THREAD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeCmd |-> !pendAny); // R7
  AST_NO_CMD_IN_THREAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeCmd |-> !thrBusy); // R8
  AST_DIR_RESIDENT: assert property (@(posedge clk) disable iff (!rstN)
    dirValidIn |-> (hit && hitIdx == curIdx)); // R5
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dirValidIn && !dirReady) |=> (dirValidIn && $stable(curIdx) && $stable(curVp) && $stable(curFromCmd))); // R10
  AST_BCAST_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (dirValidIn && dirReady && curVec && !lastVp) |=> (dirValidIn && curVp == VPW'($past(curVp) + 1'b1))); // R3

endmodule

// File: rtl/fcm_control.sv
module fcm_control
  import fcm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pendAny,
  input  logic    thrAny,
  input  logic    cmdAvail,
  input  logic    hit,
  input  logic    lastVp,
  input  logic    fillDone,
  input  logic    dirReady,
  output fcmCtl_t ctl,
  output logic    dirValid,
  output logic    fillReqValid
);
  fcmState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    dirValid     = 1'b0;
    fillReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pendAny) begin
          ctl.takeThread = 1'b1;
          stateNext      = ST_LOOK;
        end else if (cmdAvail && !thrAny) begin
          ctl.takeCmd = 1'b1;
          stateNext   = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          ctl.latchHit = 1'b1;
          stateNext    = ST_ISSUE;
        end else begin
          stateNext = ST_FREQ;
        end
      end
      ST_FREQ: begin
        fillReqValid = 1'b1;
        stateNext    = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (fillDone) begin
          ctl.install = 1'b1;
          stateNext   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        dirValid = 1'b1;
        if (dirReady) begin
          if (lastVp) begin
            ctl.finish = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            ctl.stepVp = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |=> !fillReqValid); // R6
  AST_NO_DIR_DURING_FILL: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |=> !dirValid); // R6

endmodule

// File: rtl/fetch_cmd_mgr.sv
module fetch_cmd_mgr
  import fcm_pkg::*;
#(
  parameter int NUM_VP        = 4,
  parameter int CACHE_ENTRIES = 8,
  parameter int ADDR_W        = 16,
  parameter int CMDQ_DEPTH    = 4,
  parameter int THR_OUTST     = 3,
  localparam int VPW  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int CNTW = $clog2(NUM_VP + 1),
  localparam int IDXW = (CACHE_ENTRIES > 1) ? $clog2(CACHE_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdKind,
  input  logic [VPW-1:0]    cmdVp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNTW-1:0]   cfgVpCount,
  input  logic              tfValid,
  input  logic [VPW-1:0]    tfVp,
  input  logic [ADDR_W-1:0] tfAddr,
  input  logic              doneValid,
  input  logic [VPW-1:0]    doneVp,
  input  logic              doneThread,
  output logic              fillReqValid,
  output logic [ADDR_W-1:0] fillReqAddr,
  input  logic              fillDone,
  output logic              dirValid,
  input  logic              dirReady,
  output logic [IDXW-1:0]   dirIdx,
  output logic [VPW-1:0]    dirVp,
  output logic              dirThread
);
  fcmCtl_t ctl;
  logic    pendAny, thrAny, cmdAvail, hit, lastVp;

  fcm_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pendAny     (pendAny),
    .thrAny      (thrAny),
    .cmdAvail    (cmdAvail),
    .hit         (hit),
    .lastVp      (lastVp),
    .fillDone    (fillDone),
    .dirReady    (dirReady),
    .ctl         (ctl),
    .dirValid    (dirValid),
    .fillReqValid(fillReqValid)
  );

  fcm_datapath #(
    .NUM_VP       (NUM_VP),
    .CACHE_ENTRIES(CACHE_ENTRIES),
    .ADDR_W       (ADDR_W),
    .CMDQ_DEPTH   (CMDQ_DEPTH),
    .THR_OUTST    (THR_OUTST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dirValidIn(dirValid),
    .dirReady  (dirReady),
    .cmdValid  (cmdValid),
    .cmdReady  (cmdReady),
    .cmdKind   (cmdKind),
    .cmdVp     (cmdVp),
    .cmdAddr   (cmdAddr),
    .cfgVpCount(cfgVpCount),
    .tfValid   (tfValid),
    .tfVp      (tfVp),
    .tfAddr    (tfAddr),
    .doneValid (doneValid),
    .doneVp    (doneVp),
    .doneThread(doneThread),
    .pendAny   (pendAny),
    .thrAny    (thrAny),
    .cmdAvail  (cmdAvail),
    .hit       (hit),
    .lastVp    (lastVp),
    .fillAddr  (fillReqAddr),
    .dirIdx    (dirIdx),
    .dirVp     (dirVp),
    .dirThread (dirThread)
  );

endmodule

// File: tb/sim_fetch_cmd_mgr.sv
module sim_fetch_cmd_mgr;
  localparam int NV = 4, NE = 8, AW = 16, QD = 4;
  localparam int VPW = 2, CNTW = 3, IDXW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdKind = 0, tfValid = 0, doneValid = 0, doneThread = 0;
  logic fillDone = 0, dirReady = 1;
  logic [VPW-1:0] cmdVp = '0, tfVp = '0, doneVp = '0;
  logic [AW-1:0] cmdAddr = '0, tfAddr = '0;
  logic [CNTW-1:0] cfgVpCount = CNTW'(4);
  logic cmdReady, fillReqValid, dirValid, dirThread;
  logic [AW-1:0] fillReqAddr;
  logic [IDXW-1:0] dirIdx;
  logic [VPW-1:0] dirVp;

  fetch_cmd_mgr #(.NUM_VP(NV), .CACHE_ENTRIES(NE), .ADDR_W(AW), .CMDQ_DEPTH(QD)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind),
    .cmdVp(cmdVp), .cmdAddr(cmdAddr), .cfgVpCount(cfgVpCount), .tfValid(tfValid),
    .tfVp(tfVp), .tfAddr(tfAddr), .doneValid(doneValid), .doneVp(doneVp),
    .doneThread(doneThread), .fillReqValid(fillReqValid), .fillReqAddr(fillReqAddr),
    .fillDone(fillDone), .dirValid(dirValid), .dirReady(dirReady), .dirIdx(dirIdx),
    .dirVp(dirVp), .dirThread(dirThread));

  always #10 clk = ~clk;

  typedef struct { int vp; int idx; bit thr; string tag; } exp_t;
  exp_t expQ[$];
  logic [AW-1:0] fillQ[$];
  int checks = 0, errors = 0, fillsSeen = 0, fillsExp = 0;

  // reference cache model
  logic [AW-1:0] mTag [NE];
  bit mVal [NE];
  int mRr = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic modelLook(input logic [AW-1:0] a, output int idx);
    idx = -1;
    for (int e = NE - 1; e >= 0; e--) if (mVal[e] && mTag[e] == a) idx = e;
    if (idx < 0) begin
      idx = mRr;
      mTag[mRr] = a;
      mVal[mRr] = 1'b1;
      mRr = (mRr + 1) % NE;
      fillQ.push_back(a);
      fillsExp++;
    end
  endtask

  task automatic expectDir(input int vp, input int idx, input bit thr, input string tag);
    exp_t it;
    it.vp = vp; it.idx = idx; it.thr = thr; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic tryCmd(input bit kind, input int vp, input logic [AW-1:0] a, output bit ok);
    @(posedge clk); #1;
    cmdValid = 1; cmdKind = kind; cmdVp = VPW'(vp); cmdAddr = a;
    @(negedge clk);
    ok = cmdReady;
    @(posedge clk); #1;
    cmdValid = 0;
  endtask

  task automatic pushCmd(input bit kind, input int vp, input logic [AW-1:0] a);
    bit ok;
    ok = 0;
    while (!ok) tryCmd(kind, vp, a, ok);
  endtask

  // predicts, then drives one command
  task automatic sendCmd(input bit kind, input int vp, input logic [AW-1:0] a, input string tag);
    int idx;
    modelLook(a, idx);
    if (kind) begin
      for (int v = 0; v < int'(cfgVpCount); v++) expectDir(v, idx, 0, tag);
    end else begin
      expectDir(vp, idx, 0, tag);
    end
    pushCmd(kind, vp, a);
  endtask

  task automatic pulseTf(input int vp, input logic [AW-1:0] a);
    @(posedge clk); #1;
    tfValid = 1; tfVp = VPW'(vp); tfAddr = a;
    @(posedge clk); #1;
    tfValid = 0;
  endtask

  task automatic pulseDone(input int vp, input bit withTf, input logic [AW-1:0] a);
    @(posedge clk); #1;
    doneValid = 1; doneVp = VPW'(vp); doneThread = 1;
    if (withTf) begin tfValid = 1; tfVp = VPW'(vp); tfAddr = a; end
    @(posedge clk); #1;
    doneValid = 0; tfValid = 0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic setReady(input bit r);
    @(posedge clk); #1;
    dirReady = r;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && dirValid && dirReady) begin
      if (expQ.size() == 0) begin
        check(0, "R8", "unexpected directive vp", int'(dirVp), -1);
      end else begin
        exp_t it;
        it = expQ.pop_front();
        check(int'(dirVp) == it.vp, it.tag, "dirVp", int'(dirVp), it.vp);
        check(int'(dirIdx) == it.idx, it.tag, "dirIdx", int'(dirIdx), it.idx);
        check(dirThread == it.thr, it.tag, "dirThread", int'(dirThread), int'(it.thr));
      end
    end
  end

  // fill responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && fillReqValid) begin
        fillsSeen++;
        if (fillQ.size() == 0) begin
          check(0, "R5", "unexpected fill addr", int'(fillReqAddr), -1);
        end else begin
          logic [AW-1:0] ea;
          ea = fillQ.pop_front();
          check(fillReqAddr == ea, "R6", "fill address", int'(fillReqAddr), int'(ea));
        end
        repeat (3) @(posedge clk);
        #1 fillDone = 1;
        @(posedge clk);
        #1 fillDone = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hIdx, hVp, acc, idx;
    bit ok;
    for (int e = 0; e < NE; e++) mVal[e] = 0;
    repeat (3) @(negedge clk);
    check(dirValid == 0, "R1", "dirValid in reset", int'(dirValid), 0);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    check(dirValid == 0, "R1", "dirValid after reset", int'(dirValid), 0);
    check(fillReqValid == 0, "R1", "fillReqValid after reset", int'(fillReqValid), 0);
    check(cmdReady == 1, "R1", "cmdReady after reset", int'(cmdReady), 1);

    // single fetch, miss then fill
    sendCmd(0, 2, 16'h00A0, "R4");
    drain();
    check(fillsSeen == 1, "R6", "fills after first miss", fillsSeen, 1);

    // broadcast on a resident block
    sendCmd(1, 0, 16'h00A0, "R3");
    drain();
    check(fillsSeen == 1, "R5", "no fill on hit", fillsSeen, 1);

    // broadcast over three processors, miss
    cfgVpCount = CNTW'(3);
    sendCmd(1, 0, 16'h00B0, "R3");
    drain();
    check(fillsSeen == 2, "R6", "fills after broadcast miss", fillsSeen, 2);
    cfgVpCount = CNTW'(4);

    // stalled directive holds
    setReady(0);
    sendCmd(0, 1, 16'h00A0, "R10");
    while (!dirValid) @(negedge clk);
    hIdx = int'(dirIdx); hVp = int'(dirVp);
    repeat (3) @(negedge clk);
    check(dirValid == 1, "R10", "dirValid held", int'(dirValid), 1);
    check(int'(dirVp) == hVp, "R10", "dirVp held", int'(dirVp), hVp);
    check(int'(dirIdx) == hIdx, "R10", "dirIdx held", int'(dirIdx), hIdx);
    setReady(1);
    drain();

    // queue capacity
    setReady(0);
    acc = 0;
    for (int i = 0; i < QD + 2; i++) begin
      tryCmd(0, i % NV, 16'h00B0, ok);
      if (ok) begin
        acc++;
        modelLook(16'h00B0, idx);
        expectDir(i % NV, idx, 0, "R2");
      end
    end
    check(acc == QD, "R2", "commands accepted", acc, QD);
    @(negedge clk);
    check(cmdReady == 0, "R2", "cmdReady when full", int'(cmdReady), 0);
    setReady(1);
    drain();

    // thread priority, blocking and lifetime
    setReady(0);
    sendCmd(0, 0, 16'h00A0, "R7");
    repeat (4) @(posedge clk);
    pulseTf(2, 16'h00B0);
    pulseTf(1, 16'h00A0);
    pushCmd(0, 3, 16'h00B0);
    modelLook(16'h00A0, idx); expectDir(1, idx, 1, "R7");
    modelLook(16'h00B0, idx); expectDir(2, idx, 1, "R7");
    setReady(1);
    drain();
    repeat (8) @(negedge clk);
    check(dirValid == 0, "R8", "command held while threads alive", int'(dirValid), 0);
    pulseDone(1, 0, '0);
    repeat (6) @(negedge clk);
    check(dirValid == 0, "R8", "command held while one thread alive", int'(dirValid), 0);
    modelLook(16'h00A0, idx); expectDir(2, idx, 1, "R9");
    pulseDone(2, 1, 16'h00A0);
    drain();
    repeat (6) @(negedge clk);
    check(dirValid == 0, "R9", "thread kept alive by same-cycle fetch", int'(dirValid), 0);
    modelLook(16'h00B0, idx); expectDir(3, idx, 0, "R8");
    pulseDone(2, 0, '0);
    drain();

    // round-robin replacement and wrap
    for (int i = 0; i < NE; i++) begin
      sendCmd(0, i % NV, AW'(16'h0200 + i), "R6");
      drain();
    end
    sendCmd(0, 3, 16'h00A0, "R6");
    drain();
    check(fillsSeen == fillsExp, "R6", "total fills", fillsSeen, fillsExp);
    check(fillQ.size() == 0, "R6", "fills outstanding", fillQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule